// File: doc/BRIEF.md
# Splittable Lookup Table Core with Optional Registers

This block is the logic core of one programmable cell. It takes four selected input bits and a 16-bit truth-table word, and works in one of two modes. In merged mode it computes one function of all four inputs. In split mode it computes two independent functions of the lower three inputs. Both modes read the same 16-bit word: bits 7:0 hold the lower half-table and bits 15:8 hold the upper half-table.

A configuration bit chooses whether results A, B and C come straight from the tables or from a bank of rising-edge flip-flops. A fourth output always carries the upper half-table result without a register. A cell can therefore keep state and still hand a combinational signal on to its neighbour in the same cycle.

There is no flowing data here. All pins are plain levels, so the block has no valid/ready handshake and no back-pressure. The truth table is a static parallel word.

Top module: `slut_core`

## Requirements
- R1: In split mode (`split_mode`=1), `out_a` is bit `lut_in[2:0]` of `table_word[7:0]` and `out_b` is bit `lut_in[2:0]` of `table_word[15:8]`; `lut_in[3]` has no effect on them.
- R2: In merged mode (`split_mode`=0), `out_c` is bit `lut_in[3:0]` of `table_word`: `lut_in[3]`=0 selects the lower half and `lut_in[3]`=1 selects the upper half.
- R3: In split mode, `out_c` is the OR of the two half-table results.
- R4: Within each half-table, address zero (all selected inputs low) reads the least significant bit of that half.
- R5: With `sync_mode`=1, `out_a`, `out_b` and `out_c` show the results sampled at the previous rising clock edge.
- R6: `out_b_async` always equals the upper half-table result, with no register, whatever `sync_mode` and `split_mode` are.
- R7: While `rst` is high at a rising edge, all three registers clear to 0. The registered outputs read 0 after that edge.
- R8: With `sync_mode`=0, `out_a`, `out_b` and `out_c` follow the table results combinationally in the same cycle.
- R9: In merged mode, `out_a` and `out_b` still carry the lower and upper half-table results for `lut_in[2:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output registers (rising edge) |
| rst | input | 1 | Synchronous active-high reset of the output registers |
| lut_in | input | 4 | Selected table inputs; bit 3 picks the half in merged mode |
| table_word | input | 16 | Truth table: [7:0] lower half, [15:8] upper half |
| split_mode | input | 1 | 1 = two 3-input functions, 0 = one 4-input function |
| sync_mode | input | 1 | 1 = registered A/B/C, 0 = combinational A/B/C |
| out_a | output | 1 | Lower half-table result |
| out_b | output | 1 | Upper half-table result |
| out_c | output | 1 | 4-input result (merged) or OR of halves (split) |
| out_b_async | output | 1 | Upper half-table result, never registered |

## Verification
The vector table uses asymmetric truth words such as A5C3, 0001 and 8000. These tell the lower half apart from the upper half, show whether bit 3 of the input is honoured or ignored, and show whether address zero and address fifteen land on the end bits. Merged and split entries share the same input values, so a swapped mode decode gives a different C.

Directed steps then swap the table between 00FF and FF00 in synchronous mode. A one-cycle delay on A/B/C with no delay on the asynchronous B output is told apart from a missing or misplaced register. Reset is checked at the start and in mid-run.

Sixteen cells are chained as a ripple counter and run with a gated enable and then through a full 16-bit wrap. This exercises registered feedback and the combinational carry together over many cycles.

// File: rtl/slut_pkg.sv
package slut_pkg;
  // Number of result bits that may be registered (A, B, C)
  localparam int unsigned SLUT_NRES = 3;

  typedef struct packed {
    logic a;
    logic b;
    logic c;
  } slut_res_t;
endpackage

// File: rtl/slut_half.sv
// One half-table: a 2**AW entry table addressed by AW inputs.
module slut_half #(
  parameter int unsigned AW = 3,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic [DEPTH-1:0] contents,
  input  logic [AW-1:0]    addr,
  output logic             bit_o
);
  assign bit_o = contents[addr];
endmodule

// File: rtl/slut_merge.sv
// Forms the A/B/C results from the two half-table bits.
module slut_merge
  import slut_pkg::*;
(
  input  logic      lo_bit,
  input  logic      hi_bit,
  input  logic      sel_hi,
  input  logic      split,
  output slut_res_t res
);
  always_comb begin
    res.a = lo_bit;
    res.b = hi_bit;
    if (split) res.c = lo_bit | hi_bit;
    else       res.c = sel_hi ? hi_bit : lo_bit;
  end
endmodule

// File: rtl/slut_regstage.sv
// Per-bit optional register stage with bypass.
module slut_regstage #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sync,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic r;
    always_ff @(posedge clk) begin
      if (rst) r <= 1'b0;
      else     r <= d[i];
    end
    assign q[i] = sync ? r : d[i];
  end
endmodule

// File: rtl/slut_core.sv
module slut_core
  import slut_pkg::*;
#(
  parameter int unsigned HALF_AW = 3,
  localparam int unsigned IN_W  = HALF_AW + 1,
  localparam int unsigned HALF_D = 1 << HALF_AW,
  localparam int unsigned TBL_W = 2 * HALF_D
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IN_W-1:0]  lut_in,
  input  logic [TBL_W-1:0] table_word,
  input  logic             split_mode,
  input  logic             sync_mode,
  output logic             out_a,
  output logic             out_b,
  output logic             out_c,
  output logic             out_b_async
);
  logic [1:0] half_bit;

  for (genvar h = 0; h < 2; h++) begin : g_half
    slut_half #(.AW(HALF_AW)) u_half (
      .contents (table_word[h*HALF_D +: HALF_D]),
      .addr     (lut_in[HALF_AW-1:0]),
      .bit_o    (half_bit[h])
    );
  end

  slut_res_t comb_res;
  slut_merge u_merge (
    .lo_bit (half_bit[0]),
    .hi_bit (half_bit[1]),
    .sel_hi (lut_in[HALF_AW]),
    .split  (split_mode),
    .res    (comb_res)
  );

  logic [SLUT_NRES-1:0] stage_q;
  slut_regstage #(.W(SLUT_NRES)) u_regs (
    .clk  (clk),
    .rst  (rst),
    .sync (sync_mode),
    .d    (comb_res),
    .q    (stage_q)
  );

  slut_res_t out_res;
  assign out_res     = slut_res_t'(stage_q);
  assign out_a       = out_res.a;
  assign out_b       = out_res.b;
  assign out_c       = out_res.c;
  assign out_b_async = half_bit[1];
endmodule

// File: rtl/slut_core_chk.sv
module slut_core_chk #(
  parameter int unsigned HALF_AW = 3,
  localparam int unsigned IN_W  = HALF_AW + 1,
  localparam int unsigned TBL_W = 2 << HALF_AW
) (
  input logic             clk,
  input logic             rst,
  input logic [IN_W-1:0]  lut_in,
  input logic [TBL_W-1:0] table_word,
  input logic             split_mode,
  input logic             sync_mode,
  input logic             out_a,
  input logic             out_b,
  input logic             out_c,
  input logic             out_b_async
);
  logic lo_ref, hi_ref, c_ref;
  assign lo_ref = table_word[{1'b0, lut_in[HALF_AW-1:0]}];
  assign hi_ref = table_word[{1'b1, lut_in[HALF_AW-1:0]}];
  assign c_ref  = split_mode ? (lo_ref | hi_ref) : table_word[lut_in];

  // R6
  p_async_b_r6: assert property (@(posedge clk) disable iff (rst)
    out_b_async == hi_ref);

  // R8, R1, R9
  p_comb_ab_r8: assert property (@(posedge clk) disable iff (rst)
    !sync_mode |-> (out_a == lo_ref && out_b == hi_ref));

  // R2, R3
  p_comb_c_r2: assert property (@(posedge clk) disable iff (rst)
    !sync_mode |-> out_c == c_ref);

  // R3
  p_split_or_r3: assert property (@(posedge clk) disable iff (rst)
    (!sync_mode && split_mode) |-> out_c == (out_a | out_b));

  // R5
  p_reg_delay_r5: assert property (@(posedge clk) disable iff (rst)
    (sync_mode && !$past(rst)) |->
      (out_a == $past(lo_ref) && out_b == $past(hi_ref) && out_c == $past(c_ref)));

  // R7
  p_reset_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (sync_mode && $past(rst)) |-> (!out_a && !out_b && !out_c));
endmodule

bind slut_core slut_core_chk #(.HALF_AW(HALF_AW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .lut_in      (lut_in),
  .table_word  (table_word),
  .split_mode  (split_mode),
  .sync_mode   (sync_mode),
  .out_a       (out_a),
  .out_b       (out_b),
  .out_c       (out_c),
  .out_b_async (out_b_async)
);

// File: tb/slut_core_test.sv
module slut_core_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  int total = 0;
  int bad   = 0;

  logic        rst;
  logic [3:0]  lut_in;
  logic [15:0] table_word;
  logic        split_mode, sync_mode;
  logic        out_a, out_b, out_c, out_b_async;

  slut_core uut (
    .clk(clk), .rst(rst), .lut_in(lut_in), .table_word(table_word),
    .split_mode(split_mode), .sync_mode(sync_mode),
    .out_a(out_a), .out_b(out_b), .out_c(out_c), .out_b_async(out_b_async)
  );

  // Ripple counter of sixteen cells (split, registered)
  logic        cnt_en;
  logic [15:0] cnt_val;
  for (genvar i = 0; i < 16; i++) begin : g_cell
    logic cin, q, cout, qb, qc;
    if (i == 0) begin : g_first
      assign cin = cnt_en;
    end else begin : g_next
      assign cin = g_cell[i-1].cout;
    end
    // half0: q ^ cin (0x66), half1: q & cin (0x88)
    slut_core u_cell (
      .clk(clk), .rst(rst), .lut_in({2'b00, q, cin}), .table_word(16'h8866),
      .split_mode(1'b1), .sync_mode(1'b1),
      .out_a(q), .out_b(qb), .out_c(qc), .out_b_async(cout)
    );
    assign cnt_val[i] = q;
  end

  task automatic chk(input logic ok, input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // {split, lut_in, table, a, b, c, b_async}
  localparam int NV = 12;
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 4'b0000, 16'hA5C3, 4'b1111},
    {1'b1, 4'b0010, 16'hA5C3, 4'b0111},
    {1'b1, 4'b1011, 16'hA5C3, 4'b0000},
    {1'b1, 4'b0110, 16'hA5C3, 4'b1010},
    {1'b0, 4'b0110, 16'hA5C3, 4'b1010},
    {1'b0, 4'b1110, 16'hA5C3, 4'b1000},
    {1'b0, 4'b1000, 16'hA5C3, 4'b1111},
    {1'b0, 4'b0011, 16'hA5C3, 4'b0000},
    {1'b0, 4'b0000, 16'h0001, 4'b1010},
    {1'b0, 4'b1000, 16'h0001, 4'b1000},
    {1'b0, 4'b1111, 16'h8000, 4'b0111},
    {1'b1, 4'b0111, 16'h8000, 4'b0111}
  };

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] ref_cnt;
    rst = 1'b1; lut_in = 4'h0; table_word = 16'hFFFF;
    split_mode = 1'b1; sync_mode = 1'b1; cnt_en = 1'b0;
    repeat (3) @(negedge clk);
    // R7 reset state, R6 async output unaffected by reset
    chk({out_a, out_b, out_c} == 3'b000, "R7 reset clears", {13'd0, out_a, out_b, out_c}, 16'd0);
    chk(out_b_async == 1'b1, "R6 async during reset", {15'd0, out_b_async}, 16'd1);
    chk(cnt_val == 16'd0, "R7 counter reset", cnt_val, 16'd0);

    // Combinational vector table (R1 R2 R3 R4 R8 R9)
    sync_mode = 1'b0;
    rst = 1'b0;
    for (int k = 0; k < NV; k++) begin
      split_mode = VEC[k][24];
      lut_in     = VEC[k][23:20];
      table_word = VEC[k][19:4];
      #1;
      chk({out_a, out_b, out_c, out_b_async} == VEC[k][3:0],
          $sformatf("R1/R2/R3/R4/R8/R9 vector %0d", k),
          {12'd0, out_a, out_b, out_c, out_b_async}, {12'd0, VEC[k][3:0]});
    end

    // R5 register delay versus R6 async path
    @(negedge clk);
    rst = 1'b1; sync_mode = 1'b1;
    @(negedge clk);
    rst = 1'b0; split_mode = 1'b1; lut_in = 4'b0000; table_word = 16'h00FF;
    #1;
    chk({out_a, out_b, out_c} == 3'b000, "R5 holds before edge", {13'd0, out_a, out_b, out_c}, 16'd0);
    chk(out_b_async == 1'b0, "R6 async lo", {15'd0, out_b_async}, 16'd0);
    @(negedge clk);
    chk({out_a, out_b, out_c} == 3'b101, "R5 after edge", {13'd0, out_a, out_b, out_c}, 16'd5);
    table_word = 16'hFF00;
    #1;
    chk({out_a, out_b, out_c} == 3'b101, "R5 holds old value", {13'd0, out_a, out_b, out_c}, 16'd5);
    chk(out_b_async == 1'b1, "R6 async immediate", {15'd0, out_b_async}, 16'd1);
    @(negedge clk);
    chk({out_a, out_b, out_c} == 3'b011, "R5 new value", {13'd0, out_a, out_b, out_c}, 16'd3);
    // R8 bypass takes effect at once
    table_word = 16'h00FF; sync_mode = 1'b0;
    #1;
    chk({out_a, out_b, out_c} == 3'b101, "R8 bypass immediate", {13'd0, out_a, out_b, out_c}, 16'd5);
    // R7 mid-run reset
    sync_mode = 1'b1;
    @(negedge clk);
    chk({out_a, out_b, out_c} == 3'b101, "R5 loaded before reset", {13'd0, out_a, out_b, out_c}, 16'd5);
    rst = 1'b1;
    @(negedge clk);
    chk({out_a, out_b, out_c} == 3'b000, "R7 mid-run reset", {13'd0, out_a, out_b, out_c}, 16'd0);
    rst = 1'b0;

    // Ripple counter: gated enable, then a full wrap (R5 R6 R1 R3)
    ref_cnt = 16'd0;
    for (int n = 0; n < 66000; n++) begin
      logic en_now;
      en_now = (n < 60) ? ((n % 3) != 0) : 1'b1;
      cnt_en = en_now;
      @(negedge clk);
      if (en_now) ref_cnt = ref_cnt + 16'd1;
      chk(cnt_val == ref_cnt, "R5/R6 counter chain", cnt_val, ref_cnt);
    end
    cnt_en = 1'b0;
    @(negedge clk);
    chk(cnt_val == ref_cnt, "R5 counter holds when idle", cnt_val, ref_cnt);
    finish_run();
  end
endmodule